// File: doc/BRIEF.md
# Debug Watchpoint Match Unit

This block sits beside an 8-bit CPU core and looks at every instruction just before it executes. The core presents the program counter, the opcode, the opcode's byte length from its decoder, the effective address the instruction will touch and whether that access is a read or a write. It also presents two snapshots from the video side: the current video-memory address and the sprite-memory address. The block compares all of this against a table of watchpoints held in flops. When any break condition is met, it raises a single-cycle break request.

There are three watchpoint classes. CPU-memory entries compare either the program counter or the effective address. Video-memory and sprite-memory entries only take part when the CPU touches particular mirrored video registers, and they then compare the video-side address in place of the CPU address. The block also holds three run-control mechanisms: a single-step flag, a step-out tracker that counts subroutine nesting depth, and a one-shot run-to-address slot. A level input enables a break on undefined opcodes.

Instructions arrive on a valid/ready stream. `insn_ready` is held high, so the unit never back-pressures the core: every cycle with `insn_valid` high is one evaluated instruction. Table writes and run-control requests are plain single-cycle strobes.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, `brk_pulse` is low and every table entry and the one-shot slot are cleared, so no instruction raises a break. `insn_ready` is high at all times.
- R2: A table entry takes part only if its enable flag (bit 0) is set and one of its type flags agrees with the current access. The type flags are read (bit 1), write (bit 2) and execute (bit 3). Every instruction counts as an execute access, in addition to any read or write.
- R3: A CPU-class entry whose execute flag is set compares the program counter. Any other CPU-class entry compares the effective address. The class field is bits 5:4: 0 or 3 selects CPU, 1 selects video, 2 selects sprite.
- R4: If an entry's end address is nonzero, it matches any value from its start address to its end address, both limits included. If the end address is zero, only a value equal to the start address matches.
- R5: A video-class entry is evaluated only when the effective address lies in 0x2000..0x3FFF and its low three bits are 7. It then compares `vram_addr`.
- R6: A sprite-class entry is evaluated when the effective address lies in 0x2000..0x3FFF and its low three bits are 4; it then compares `spr_addr`. Independently of that, an enabled sprite-class entry with its write flag set fires whenever the effective address is 0x4014.
- R7: The one-shot slot fires when its flags are nonzero and its address equals the program counter. Firing clears the slot, so the same address does not break a second time.
- R8: A `step_req` strobe arms single-step. The next evaluated instruction then breaks and disarms it.
- R9: A `stepout_req` strobe enters step-out mode with a depth of zero. While in step-out mode, opcode 0x20 increments the depth. Opcode 0x60 decrements the depth if it is nonzero. If the depth is zero, opcode 0x60 leaves step-out mode and arms single-step, so the following instruction breaks.
- R10: When `badop_en` is high, an instruction whose `insn_size` is 0 raises a break.
- R11: The break for an instruction appears on `brk_pulse` for exactly one cycle, on the cycle after `insn_valid`. Some sources mask others on the same instruction. A step-out exit suppresses the step, one-shot and table checks for that instruction. An armed step suppresses the one-shot and table checks. A one-shot hit suppresses the table check.
- R12: A table write with `cfg_sel` below 8 targets that entry. `cfg_field` selects what is written: 0 writes the start address, 1 the end address, 2 the flags. Field 3 is ignored. `cfg_sel` equal to 8 addresses the one-shot slot, where field 0 is the address and field 2 the flags. Any other selector value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 4 | Entry selector (8 = one-shot slot) |
| cfg_field | input | 2 | Field selector |
| cfg_wdata | input | 16 | Write data |
| step_req | input | 1 | Arm single-step |
| stepout_req | input | 1 | Enter step-out mode |
| badop_en | input | 1 | Enable break on undefined opcode |
| insn_valid | input | 1 | Instruction present for evaluation |
| insn_ready | output | 1 | Always high; no back-pressure |
| insn_pc | input | 16 | Program counter of the instruction |
| insn_opcode | input | 8 | Opcode byte |
| insn_size | input | 2 | Opcode length, 0 = undefined |
| insn_ea | input | 16 | Effective address |
| insn_rd | input | 1 | Instruction reads the effective address |
| insn_wr | input | 1 | Instruction writes the effective address |
| vram_addr | input | 16 | Video-memory address snapshot |
| spr_addr | input | 8 | Sprite-memory address snapshot |
| brk_pulse | output | 1 | One-cycle break request |

## Verification
The bench sweeps effective addresses through low memory, the mirrored video-register window and the region around 0x4014, and sweeps the program counter, under read, write and no-data accesses. These sweeps catch a range check that drops an inclusive limit, a video or sprite entry that ignores the low-bit register selector, and an execute-flagged entry that wrongly compares the effective address. Directed sequences follow step-out nesting through two calls and returns. A design that exits on the first return, or breaks on the exiting return itself, shows up here. Other sequences stack a step-out exit, a pending step and a one-shot hit on one address, exposing a one-shot that fires under a step or is never cleared. Writes to the ignored field and to out-of-range selectors check that they leave the table unchanged.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  localparam int AW = 16;
  localparam int FW = 6;

  localparam int FB_EN = 0;
  localparam int FB_RD = 1;
  localparam int FB_WR = 2;
  localparam int FB_EX = 3;
  localparam int FB_KIND_LO = 4;

  typedef enum logic [1:0] {
    WK_CPU    = 2'd0,
    WK_VIDEO  = 2'd1,
    WK_SPRITE = 2'd2,
    WK_RSVD   = 2'd3
  } wp_kind_e;

  typedef struct packed {
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    logic [FW-1:0] flags;
  } wp_entry_t;

  typedef enum logic [1:0] {
    CF_START = 2'd0,
    CF_END   = 2'd1,
    CF_FLAGS = 2'd2,
    CF_NONE  = 2'd3
  } cfg_field_e;

  function automatic logic addr_hit(input logic [AW-1:0] v,
                                    input logic [AW-1:0] lo,
                                    input logic [AW-1:0] hi);
    if (hi != '0) return (v >= lo) && (v <= hi);
    return v == lo;
  endfunction
endpackage

// File: rtl/dbg_wp_table.sv
module dbg_wp_table
  import dbg_watch_pkg::*;
#(
  parameter int NUM_WP = 8,
  parameter int SEL_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [1:0]      cfg_field,
  input  logic [AW-1:0]   cfg_wdata,
  output wp_entry_t       ent [NUM_WP]
);
  for (genvar g = 0; g < NUM_WP; g++) begin : g_ent
    wp_entry_t r;
    logic      sel_me;
    assign sel_me = cfg_we && (cfg_sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= '0;
      end else if (sel_me) begin
        case (cfg_field_e'(cfg_field))
          CF_START: r.lo    <= cfg_wdata;
          CF_END:   r.hi    <= cfg_wdata;
          CF_FLAGS: r.flags <= cfg_wdata[FW-1:0];
          default:  r       <= r;
        endcase
      end
    end
    assign ent[g] = r;
  end
endmodule

// File: rtl/dbg_wp_compare.sv
module dbg_wp_compare
  import dbg_watch_pkg::*;
#(
  parameter logic [AW-1:0] WIN_LO   = 16'h2000,
  parameter logic [AW-1:0] WIN_HI   = 16'h3FFF,
  parameter logic [2:0]    VRAM_REG = 3'd7,
  parameter logic [2:0]    SPR_REG  = 3'd4,
  parameter logic [AW-1:0] DMA_ADDR = 16'h4014,
  parameter int            SPR_W    = 8
) (
  input  wp_entry_t        ent,
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    ea,
  input  logic             rd,
  input  logic             wr,
  input  logic [AW-1:0]    vram,
  input  logic [SPR_W-1:0] spr,
  output logic             hit
);
  logic       en, type_ok, in_win, vram_sel, spr_sel;
  logic [2:0] acc;
  logic [AW-1:0] cpu_val;
  wp_kind_e   kind;

  always_comb begin
    en       = ent.flags[FB_EN];
    acc      = {1'b1, wr, rd};
    type_ok  = en && |(ent.flags[FB_EX:FB_RD] & acc);
    kind     = wp_kind_e'(ent.flags[FB_KIND_LO+1:FB_KIND_LO]);
    cpu_val  = ent.flags[FB_EX] ? pc : ea;
    in_win   = (ea >= WIN_LO) && (ea <= WIN_HI);
    vram_sel = in_win && (ea[2:0] == VRAM_REG);
    spr_sel  = in_win && (ea[2:0] == SPR_REG);
    case (kind)
      WK_VIDEO:  hit = type_ok && vram_sel && addr_hit(vram, ent.lo, ent.hi);
      WK_SPRITE: hit = (type_ok && spr_sel &&
                        addr_hit(AW'(spr), ent.lo, ent.hi)) ||
                       (en && ent.flags[FB_WR] && (ea == DMA_ADDR));
      default:   hit = type_ok && addr_hit(cpu_val, ent.lo, ent.hi);
    endcase
  end
endmodule

// File: rtl/dbg_step_ctrl.sv
module dbg_step_ctrl
  import dbg_watch_pkg::*;
#(
  parameter int         NUM_WP  = 8,
  parameter int         SEL_W   = 4,
  parameter int         DEPTH_W = 8,
  parameter logic [7:0] CALL_OP = 8'h20,
  parameter logic [7:0] RET_OP  = 8'h60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [1:0]         cfg_field,
  input  logic [AW-1:0]      cfg_wdata,
  input  logic               step_req,
  input  logic               stepout_req,
  input  logic               insn_valid,
  input  logic [AW-1:0]      insn_pc,
  input  logic [7:0]         insn_opcode,
  output logic               step_fire,
  output logic               os_fire,
  output logic               wp_allow,
  output logic               step_armed,
  output logic               so_active,
  output logic [DEPTH_W-1:0] so_depth,
  output logic               os_armed
);
  logic [AW-1:0] os_addr;
  logic [FW-1:0] os_flags;
  logic so_exit, os_match, os_sel;

  always_comb begin
    os_armed  = |os_flags;
    os_match  = os_armed && (os_addr == insn_pc);
    so_exit   = so_active && (insn_opcode == RET_OP) && (so_depth == '0);
    step_fire = insn_valid && !so_exit && step_armed;
    os_fire   = insn_valid && !so_exit && !step_armed && os_match;
    wp_allow  = !so_exit && !step_armed && !os_match;
    os_sel    = cfg_we && (cfg_sel == SEL_W'(NUM_WP));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_armed <= 1'b0;
      so_active  <= 1'b0;
      so_depth   <= '0;
      os_addr    <= '0;
      os_flags   <= '0;
    end else begin
      if (insn_valid) begin
        if (so_active) begin
          if (insn_opcode == CALL_OP) begin
            so_depth <= so_depth + 1'b1;
          end else if (insn_opcode == RET_OP) begin
            if (so_depth != '0) so_depth <= so_depth - 1'b1;
            else                so_active <= 1'b0;
          end
        end
        if (so_exit)         step_armed <= 1'b1;
        else if (step_armed) step_armed <= 1'b0;
        if (os_fire) begin
          os_addr  <= '0;
          os_flags <= '0;
        end
      end
      if (os_sel) begin
        if (cfg_field == CF_START) os_addr  <= cfg_wdata;
        if (cfg_field == CF_FLAGS) os_flags <= cfg_wdata[FW-1:0];
      end
      if (step_req) step_armed <= 1'b1;
      if (stepout_req) begin
        so_active <= 1'b1;
        so_depth  <= '0;
      end
    end
  end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int NUM_WP  = 8,
  parameter int DEPTH_W = 8,
  parameter int SPR_W   = 8,
  parameter logic [7:0] CALL_OP = 8'h20,
  parameter logic [7:0] RET_OP  = 8'h60,
  localparam int SEL_W = $clog2(NUM_WP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [1:0]       cfg_field,
  input  logic [15:0]      cfg_wdata,
  input  logic             step_req,
  input  logic             stepout_req,
  input  logic             badop_en,
  input  logic             insn_valid,
  output logic             insn_ready,
  input  logic [15:0]      insn_pc,
  input  logic [7:0]       insn_opcode,
  input  logic [1:0]       insn_size,
  input  logic [15:0]      insn_ea,
  input  logic             insn_rd,
  input  logic             insn_wr,
  input  logic [15:0]      vram_addr,
  input  logic [SPR_W-1:0] spr_addr,
  output logic             brk_pulse
);
  wp_entry_t          ent [NUM_WP];
  logic [NUM_WP-1:0]  wp_hit;
  logic               step_fire, os_fire, wp_allow;
  logic               step_armed, so_active, os_armed;
  logic [DEPTH_W-1:0] so_depth;
  logic               bad_hit, brk_next;

  assign insn_ready = 1'b1;

  dbg_wp_table #(.NUM_WP(NUM_WP), .SEL_W(SEL_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .ent(ent)
  );

  for (genvar g = 0; g < NUM_WP; g++) begin : g_cmp
    dbg_wp_compare #(.SPR_W(SPR_W)) u_cmp (
      .ent(ent[g]), .pc(insn_pc), .ea(insn_ea), .rd(insn_rd), .wr(insn_wr),
      .vram(vram_addr), .spr(spr_addr), .hit(wp_hit[g])
    );
  end

  dbg_step_ctrl #(
    .NUM_WP(NUM_WP), .SEL_W(SEL_W), .DEPTH_W(DEPTH_W),
    .CALL_OP(CALL_OP), .RET_OP(RET_OP)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .step_req(step_req),
    .stepout_req(stepout_req), .insn_valid(insn_valid), .insn_pc(insn_pc),
    .insn_opcode(insn_opcode), .step_fire(step_fire), .os_fire(os_fire),
    .wp_allow(wp_allow), .step_armed(step_armed), .so_active(so_active),
    .so_depth(so_depth), .os_armed(os_armed)
  );

  always_comb begin
    bad_hit  = badop_en && (insn_size == 2'd0);
    brk_next = insn_valid &&
               (bad_hit || step_fire || os_fire || (wp_allow && |wp_hit));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) brk_pulse <= 1'b0;
    else        brk_pulse <= brk_next;
  end
endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk #(
  parameter int DEPTH_W = 8,
  parameter logic [7:0] RET_OP = 8'h60
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               stepout_req,
  input logic               badop_en,
  input logic               insn_valid,
  input logic [7:0]         insn_opcode,
  input logic [1:0]         insn_size,
  input logic               brk_pulse,
  input logic               step_armed,
  input logic               so_active,
  input logic [DEPTH_W-1:0] so_depth,
  input logic               os_armed
);
  AST_PULSE_NEEDS_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(insn_valid)); // R11
  AST_BADOP_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && badop_en && insn_size == 2'd0) |=> brk_pulse); // R10
  AST_STEP_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && step_armed &&
     !(so_active && insn_opcode == RET_OP && so_depth == '0)) |=> brk_pulse); // R8
  AST_STEPOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && so_active && insn_opcode == RET_OP && so_depth == '0 &&
     !stepout_req) |=> (!so_active && step_armed)); // R9
  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(os_armed) |-> (brk_pulse || $past(cfg_we))); // R7
endmodule

bind dbg_watch_unit dbg_watch_chk #(.DEPTH_W(DEPTH_W), .RET_OP(RET_OP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .stepout_req(stepout_req),
  .badop_en(badop_en), .insn_valid(insn_valid), .insn_opcode(insn_opcode),
  .insn_size(insn_size), .brk_pulse(brk_pulse), .step_armed(step_armed),
  .so_active(so_active), .so_depth(so_depth), .os_armed(os_armed)
);

// File: tb/dbg_watch_unit_bench.sv
module dbg_watch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [1:0]  cfg_field = '0;
  logic [15:0] cfg_wdata = '0;
  logic        step_req = 1'b0, stepout_req = 1'b0, badop_en = 1'b0;
  logic        insn_valid = 1'b0, insn_ready;
  logic [15:0] insn_pc = '0, insn_ea = '0, vram_addr = '0;
  logic [7:0]  insn_opcode = 8'hEA, spr_addr = '0;
  logic [1:0]  insn_size = 2'd1;
  logic        insn_rd = 1'b0, insn_wr = 1'b0;
  logic        brk_pulse;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_lo [8];
  logic [15:0] m_hi [8];
  logic [5:0]  m_fl [8];

  always #2.5 clk = ~clk;

  dbg_watch_unit u_dbg_watch_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .step_req(step_req),
    .stepout_req(stepout_req), .badop_en(badop_en), .insn_valid(insn_valid),
    .insn_ready(insn_ready), .insn_pc(insn_pc), .insn_opcode(insn_opcode),
    .insn_size(insn_size), .insn_ea(insn_ea), .insn_rd(insn_rd),
    .insn_wr(insn_wr), .vram_addr(vram_addr), .spr_addr(spr_addr),
    .brk_pulse(brk_pulse)
  );

  function automatic bit rng(input logic [15:0] v, lo, hi);
    return (hi != 0) ? (v >= lo && v <= hi) : (v == lo);
  endfunction

  // expected table result from R2..R6
  function automatic bit m_hit(input logic [15:0] pc, ea, vr, input logic [7:0] sp,
                               input bit rd, wr);
    bit h = 0;
    for (int i = 0; i < 8; i++) begin
      bit ok = m_fl[i][0] && ((m_fl[i][1] && rd) || (m_fl[i][2] && wr) || m_fl[i][3]);
      bit win = (ea >= 16'h2000) && (ea <= 16'h3FFF);
      case (m_fl[i][5:4])
        2'd1: h |= ok && win && (ea % 8 == 7) && rng(vr, m_lo[i], m_hi[i]);
        2'd2: h |= (ok && win && (ea % 8 == 4) && rng({8'h00, sp}, m_lo[i], m_hi[i])) ||
                   (m_fl[i][0] && m_fl[i][2] && ea == 16'h4014);
        default: h |= ok && rng(m_fl[i][3] ? pc : ea, m_lo[i], m_hi[i]);
      endcase
    end
    return h;
  endfunction

  task automatic check(input bit got, exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: brk_pulse=%0b expected %0b (pc=%h ea=%h)", req, got, exp,
               insn_pc, insn_ea);
    end
  endtask

  task automatic wcfg(input logic [3:0] sel, input logic [1:0] f, input logic [15:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_ent(input int i, input logic [15:0] lo, hi, input logic [5:0] fl);
    wcfg(4'(i), 2'd0, lo); wcfg(4'(i), 2'd1, hi); wcfg(4'(i), 2'd2, {10'h0, fl});
    m_lo[i] = lo; m_hi[i] = hi; m_fl[i] = fl;
  endtask

  task automatic insn(input logic [15:0] pc, ea, input logic [7:0] op,
                      input bit rd, wr, input bit exp, input string req);
    insn_pc = pc; insn_ea = ea; insn_opcode = op; insn_rd = rd; insn_wr = wr;
    insn_valid = 1;
    @(negedge clk);
    insn_valid = 0;
    check(brk_pulse, exp, req);
  endtask

  task automatic pulse_step(input bit so);
    if (so) stepout_req = 1; else step_req = 1;
    @(negedge clk);
    step_req = 0; stepout_req = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_fl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(brk_pulse, 1'b0, "R1 reset");
    check(insn_ready, 1'b1, "R1 ready");
    insn(16'h0000, 16'h0000, 8'hEA, 1, 0, 1'b0, "R1 empty table");

    // flags: [0]en [1]rd [2]wr [3]ex [5:4] class 0 cpu 1 video 2 sprite
    set_ent(0, 16'h0010, 16'h0000, 6'b00_1001); // cpu exec exact
    set_ent(1, 16'h0020, 16'h0027, 6'b00_0011); // cpu read range
    set_ent(2, 16'h0030, 16'h0000, 6'b00_0101); // cpu write exact
    set_ent(3, 16'h0005, 16'h003F, 6'b00_0110); // disabled
    set_ent(4, 16'h0100, 16'h0102, 6'b01_0111); // video rd|wr
    set_ent(5, 16'h0040, 16'h0000, 6'b10_0101); // sprite write
    set_ent(6, 16'h0038, 16'h003A, 6'b00_1011); // cpu exec|rd range -> pc
    set_ent(7, 16'h2007, 16'h0000, 6'b00_0011); // cpu read exact

    // effective-address sweep under three access kinds
    for (int i = 0; i < 104; i++) begin
      logic [15:0] ea = (i < 64) ? 16'(i) : (i < 96) ? 16'(16'h2000 + i - 64)
                                                     : 16'(16'h4010 + i - 96);
      for (int k = 0; k < 3; k++) begin
        vram_addr = 16'h00FE + 16'(ea[4:3]);
        spr_addr  = 8'h3E + 8'(ea[4:3]);
        insn(16'h1000, ea, 8'hEA, k == 0, k == 1,
             m_hit(16'h1000, ea, vram_addr, spr_addr, k == 0, k == 1),
             "R2/R3/R4/R5/R6 ea sweep");
      end
    end
    // program-counter sweep, no data access
    vram_addr = 0; spr_addr = 0;
    for (int p = 0; p < 64; p++)
      insn(16'(p), 16'h1000, 8'hEA, 0, 0, m_hit(16'(p), 16'h1000, 0, 0, 0, 0),
           "R3/R4 pc sweep");

    // R12: ignored field and ignored selector
    wcfg(4'd0, 2'd3, 16'h0011);
    insn(16'h0010, 16'h1000, 8'hEA, 0, 0, 1'b1, "R12 field3 ignored");
    insn(16'h0011, 16'h1000, 8'hEA, 0, 0, 1'b0, "R12 field3 ignored");
    wcfg(4'd9, 2'd0, 16'h1000);
    wcfg(4'd9, 2'd2, 16'h0003);
    insn(16'h1000, 16'h1000, 8'hEA, 1, 0, 1'b0, "R12 selector 9 ignored");

    // R8 single step
    pulse_step(0);
    insn(16'h1000, 16'h1000, 8'hEA, 0, 0, 1'b1, "R8 step breaks");
    insn(16'h1000, 16'h1000, 8'hEA, 0, 0, 1'b0, "R8 step disarmed");

    // R9 step-out nesting
    pulse_step(1);
    insn(16'h1000, 16'h1000, 8'h20, 0, 0, 1'b0, "R9 call");
    insn(16'h1000, 16'h1000, 8'h20, 0, 0, 1'b0, "R9 call");
    insn(16'h1000, 16'h1000, 8'h60, 0, 0, 1'b0, "R9 return nested");
    insn(16'h1000, 16'h1000, 8'h60, 0, 0, 1'b0, "R9 return nested");
    insn(16'h1000, 16'h1000, 8'h60, 0, 0, 1'b0, "R9 exiting return");
    insn(16'h1000, 16'h1000, 8'hEA, 0, 0, 1'b1, "R9 break after exit");
    insn(16'h1000, 16'h1000, 8'h60, 0, 0, 1'b0, "R9 mode left");

    // R7/R11 one-shot with priorities
    wcfg(4'd8, 2'd0, 16'h1234);
    wcfg(4'd8, 2'd2, 16'h0001);
    pulse_step(1);
    insn(16'h1234, 16'h1000, 8'h60, 0, 0, 1'b0, "R11 exit masks one-shot");
    insn(16'h1234, 16'h1000, 8'hEA, 0, 0, 1'b1, "R11 step before one-shot");
    insn(16'h1234, 16'h1000, 8'hEA, 0, 0, 1'b1, "R7 one-shot fires");
    insn(16'h1234, 16'h1000, 8'hEA, 0, 0, 1'b0, "R7 one-shot cleared");
    wcfg(4'd8, 2'd0, 16'h0050);
    insn(16'h0050, 16'h1000, 8'hEA, 0, 0, 1'b0, "R7 zero flags never fire");

    // R10 undefined opcode
    badop_en = 1; insn_size = 2'd0;
    insn(16'h1000, 16'h1000, 8'h02, 0, 0, 1'b1, "R10 bad opcode");
    insn_size = 2'd1;
    insn(16'h1000, 16'h1000, 8'hEA, 0, 0, 1'b0, "R10 good opcode");
    badop_en = 0; insn_size = 2'd0;
    insn(16'h1000, 16'h1000, 8'h02, 0, 0, 1'b0, "R10 disabled");
    insn_size = 2'd1;

    // R11 pulse width: idle cycle after a hit
    insn(16'h0010, 16'h1000, 8'hEA, 0, 0, 1'b1, "R11 hit");
    @(negedge clk);
    check(brk_pulse, 1'b0, "R11 single cycle");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule